// File: doc/BRIEF.md
# K-Best Detector Tree Level Stage

This block is one pipelined level of a breadth-first K-best search for spatially multiplexed MIMO detection. The complex 4x4 channel is treated as a real-valued problem of dimension eight, so a full detector has eight tree levels. The search starts at the level of the last diagonal entry of the triangular factor and climbs upward. Each level keeps only the K = 8 partial paths with the smallest accumulated partial Euclidean distance (PED). The block receives eight surviving paths in lanes. Each lane carries its accumulated PED, its decided-symbol history, and the per-lane received value with the contributions of already-decided symbols removed. The block also receives the diagonal R entry of this level. It returns eight extended paths with updated PEDs and histories.

A `MODE` parameter selects one of three stage variants. The root variant evaluates every symbol of the real 8-PAM alphabet once, one per lane. The full-expansion variant (second level) expands all 8 survivors by all 8 symbols and keeps the best 8 of the 64 candidates through a pipelined rank-and-scatter network. The nearest-node variant (deeper levels) extends each survivor only by the symbol closest to its own received value, so it needs no sort. One instance serves each tree level, and each instance accepts a new input set every clock cycle.

Top module: `kbest_level_stage`

## Requirements
- R1: Symbol index i (0..7) stands for the real value 2i-7. Each output history is the parent history shifted left by 3 bits, with the chosen index in bits [2:0] and the top 3 bits dropped.
- R2: A candidate PED equals the parent PED plus (b - r*s)^2, where b (lane input) and r (`r_diag`) are two's-complement signed and s is the symbol value.
- R3: The PED addition saturates: any sum above the all-ones value of the PED field yields all ones.
- R4: In root mode, lane p is extended by symbol index p and appears in output slot p, one cycle after the input.
- R5: In full-expansion mode, candidate c = 8p + i (lane p, symbol index i) is formed for all 64 pairs. The 8 candidates with the smallest PED appear in slots 0..7 in ascending PED order, three cycles after the input.
- R6: In full-expansion mode, among equal PEDs the lower candidate index c ranks first, both in the selection and in the slot order.
- R7: In nearest mode, with `r_diag` > 0, lane p is extended by the symbol minimizing (b - r*s)^2. This is the odd integer closest to b/r, saturated to ±7, with an exact tie taking the lower index. The result appears in slot p one cycle after the input.
- R8: `out_valid` repeats `in_valid` delayed by the mode latency (1, or 3 for full expansion). Input sets on consecutive cycles produce results on consecutive cycles.
- R9: While `rst_n` is low and until valid data has passed through, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input lane set is valid this cycle |
| in_ped | input | K*PW (320) | Parent PEDs, lane p at [p*PW +: PW] |
| in_b | input | K*BW (96) | Signed per-lane received value for this level |
| in_hist | input | K*HW (192) | Parent symbol histories, 3 bits per level |
| r_diag | input | RW (12) | Signed diagonal R entry of this level |
| out_valid | output | 1 | Output slot set is valid |
| out_ped | output | K*PW (320) | Survivor PEDs, slot k at [k*PW +: PW] |
| out_hist | output | K*HW (192) | Survivor histories |

## Verification
The hardest situation to reach from the ports is a dense set of equal PEDs across lanes in full-expansion mode. Only that case exercises the index-based tie order of the rank network. The bench reaches it by driving all eight lanes with the same PED and received value but distinct histories, so the lane order is visible in the surviving histories. Exact slicing ties in nearest mode come from received values that are even multiples of `r_diag`. Saturation comes from parent PEDs at or just below the all-ones value.

// File: rtl/kbest_pkg.sv
package kbest_pkg;
    localparam int ALPHA  = 8;
    localparam int IDX_W  = 3;
    localparam int SYM_W  = 4;

    localparam int MODE_ROOT    = 0;
    localparam int MODE_FULL    = 1;
    localparam int MODE_NEAREST = 2;

    // index i -> 2i-7 : {i,1} is 2i+1, flipping the 4-bit sign subtracts 8
    function automatic logic signed [SYM_W-1:0] idx_to_sym(input logic [IDX_W-1:0] idx);
        return {~idx[2], idx[1:0], 1'b1};
    endfunction
endpackage

// File: rtl/kbest_err_unit.sv
module kbest_err_unit
    import kbest_pkg::*;
#(
    parameter int BW = 12,
    parameter int RW = 12,
    parameter int EW = 34
) (
    input  logic signed [BW-1:0] b,
    input  logic signed [RW-1:0] r,
    input  logic [IDX_W-1:0]     idx,
    output logic [EW-1:0]        err2
);
    localparam int DW = EW / 2;

    logic signed [SYM_W-1:0]    sym;
    logic signed [RW+SYM_W-1:0] prod;
    logic signed [DW-1:0]       diff;
    logic signed [EW-1:0]       sq;

    always_comb begin
        sym  = idx_to_sym(idx);
        prod = r * sym;
        diff = DW'(b) - DW'(prod);
        sq   = diff * diff;
        err2 = $unsigned(sq);
    end
endmodule

// File: rtl/kbest_rank_select.sv
module kbest_rank_select #(
    parameter int NC = 64,
    parameter int K  = 8,
    parameter int PW = 40,
    parameter int HW = 24
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [NC-1:0][PW-1:0] in_ped,
    input  logic [NC-1:0][HW-1:0] in_hist,
    output logic                  out_valid,
    output logic [K-1:0][PW-1:0]  out_ped,
    output logic [K-1:0][HW-1:0]  out_hist
);
    localparam int RKW = $clog2(NC);

    typedef struct packed {
        logic                   valid;
        logic [NC-1:0][PW-1:0]  ped;
        logic [NC-1:0][HW-1:0]  hist;
        logic [NC-1:0][RKW-1:0] rank;
    } rank_st_t;

    typedef struct packed {
        logic                  valid;
        logic [K-1:0][PW-1:0]  ped;
        logic [K-1:0][HW-1:0]  hist;
    } pick_st_t;

    rank_st_t rk_d, rk_q;
    pick_st_t pk_d, pk_q;
    logic [K-1:0][NC-1:0] slot_hit;

    always_comb begin
        logic [RKW-1:0] cnt;
        rk_d.valid = in_valid;
        rk_d.ped   = in_ped;
        rk_d.hist  = in_hist;
        for (int c = 0; c < NC; c++) begin
            cnt = '0;
            for (int j = 0; j < NC; j++) begin
                if (j != c) begin
                    if ((in_ped[j] < in_ped[c]) || ((in_ped[j] == in_ped[c]) && (j < c)))
                        cnt = cnt + 1'b1;
                end
            end
            rk_d.rank[c] = cnt;
        end

        pk_d       = '0;
        pk_d.valid = rk_q.valid;
        for (int k = 0; k < K; k++) begin
            for (int c = 0; c < NC; c++) begin
                slot_hit[k][c] = (rk_q.rank[c] == RKW'(k));
                if (slot_hit[k][c]) begin
                    pk_d.ped[k]  = rk_q.ped[c];
                    pk_d.hist[k] = rk_q.hist[c];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rk_q <= '0;
            pk_q <= '0;
        end else begin
            rk_q <= rk_d;
            pk_q <= pk_d;
        end
    end

    assign out_valid = pk_q.valid;
    assign out_ped   = pk_q.ped;
    assign out_hist  = pk_q.hist;

    for (genvar k = 0; k < K; k++) begin : g_chk
        assert_one_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
            rk_q.valid |-> ($countones(slot_hit[k]) == 1));
        if (k < K - 1) begin : g_ord
            assert_sorted_R5: assert property (@(posedge clk) disable iff (!rst_n)
                pk_q.valid |-> (pk_q.ped[k] <= pk_q.ped[k+1]));
        end
    end
endmodule

// File: rtl/kbest_level_stage.sv
module kbest_level_stage
    import kbest_pkg::*;
#(
    parameter int MODE   = MODE_FULL,
    parameter int K      = 8,
    parameter int BW     = 12,
    parameter int RW     = 12,
    parameter int PW     = 40,
    parameter int LEVELS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [K*PW-1:0]            in_ped,
    input  logic [K*BW-1:0]            in_b,
    input  logic [K*LEVELS*IDX_W-1:0]  in_hist,
    input  logic [RW-1:0]              r_diag,
    output logic                       out_valid,
    output logic [K*PW-1:0]            out_ped,
    output logic [K*LEVELS*IDX_W-1:0]  out_hist
);
    localparam int HW  = LEVELS * IDX_W;
    localparam int DW  = ((BW > RW + SYM_W) ? BW : RW + SYM_W) + 1;
    localparam int EW  = 2 * DW;
    localparam int NS  = (MODE == MODE_ROOT) ? 1 : ALPHA;
    localparam int NC  = (MODE == MODE_FULL) ? K * ALPHA : K;
    localparam int LAT = (MODE == MODE_FULL) ? 3 : 1;

    typedef struct packed {
        logic                  valid;
        logic [NC-1:0][PW-1:0] ped;
        logic [NC-1:0][HW-1:0] hist;
    } cand_st_t;

    cand_st_t cs_d, cs_q;
    logic [K-1:0][NS-1:0][EW-1:0] err;

    function automatic logic [PW-1:0] sat_add(input logic [PW-1:0] a, input logic [EW-1:0] e);
        logic [PW:0] s;
        s = {1'b0, a} + {{(PW + 1 - EW){1'b0}}, e};
        return s[PW] ? {PW{1'b1}} : s[PW-1:0];
    endfunction

    for (genvar p = 0; p < K; p++) begin : g_lane
        for (genvar s = 0; s < NS; s++) begin : g_sym
            kbest_err_unit #(.BW(BW), .RW(RW), .EW(EW)) u_err (
                .b    (in_b[p*BW +: BW]),
                .r    (r_diag),
                .idx  (IDX_W'((MODE == MODE_ROOT) ? p : s)),
                .err2 (err[p][s])
            );
        end
    end

    if (MODE == MODE_FULL) begin : g_full_front
        always_comb begin
            cs_d       = '0;
            cs_d.valid = in_valid;
            for (int p = 0; p < K; p++) begin
                for (int s = 0; s < ALPHA; s++) begin
                    cs_d.ped[p*ALPHA+s]  = sat_add(in_ped[p*PW +: PW], err[p][s]);
                    cs_d.hist[p*ALPHA+s] = {in_hist[p*HW +: HW-IDX_W], IDX_W'(s)};
                end
            end
        end
    end else if (MODE == MODE_NEAREST) begin : g_near_front
        logic [K-1:0][IDX_W-1:0] near_idx;
        always_comb begin
            cs_d       = '0;
            cs_d.valid = in_valid;
            for (int p = 0; p < K; p++) begin
                near_idx[p] = '0;
                for (int s = 1; s < ALPHA; s++) begin
                    if (err[p][s] < err[p][near_idx[p]])
                        near_idx[p] = IDX_W'(s);
                end
                cs_d.ped[p]  = sat_add(in_ped[p*PW +: PW], err[p][near_idx[p]]);
                cs_d.hist[p] = {in_hist[p*HW +: HW-IDX_W], near_idx[p]};
            end
        end
        for (genvar p = 0; p < K; p++) begin : g_nchk
            for (genvar s = 0; s < ALPHA; s++) begin : g_s
                assert_nearest_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
                    in_valid |-> (err[p][near_idx[p]] <= err[p][s]));
            end
        end
    end else begin : g_root_front
        always_comb begin
            cs_d       = '0;
            cs_d.valid = in_valid;
            for (int p = 0; p < K; p++) begin
                cs_d.ped[p]  = sat_add(in_ped[p*PW +: PW], err[p][0]);
                cs_d.hist[p] = {in_hist[p*HW +: HW-IDX_W], IDX_W'(p)};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    if (MODE == MODE_FULL) begin : g_select
        logic [K-1:0][PW-1:0] sel_ped;
        logic [K-1:0][HW-1:0] sel_hist;
        kbest_rank_select #(.NC(NC), .K(K), .PW(PW), .HW(HW)) u_sel (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (cs_q.valid),
            .in_ped    (cs_q.ped),
            .in_hist   (cs_q.hist),
            .out_valid (out_valid),
            .out_ped   (sel_ped),
            .out_hist  (sel_hist)
        );
        assign out_ped  = sel_ped;
        assign out_hist = sel_hist;
    end else begin : g_direct
        assign out_valid = cs_q.valid;
        assign out_ped   = cs_q.ped;
        assign out_hist  = cs_q.hist;
        for (genvar p = 0; p < K; p++) begin : g_sat
            assert_ped_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && (in_ped[p*PW +: PW] == {PW{1'b1}}))
                |=> (out_ped[p*PW +: PW] == {PW{1'b1}}));
        end
    end

    // cycles since reset release, saturating at LAT, so $past stays inside them
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                  age_q <= '0;
        else if (age_q != 2'(LAT))   age_q <= age_q + 2'd1;
    end

    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'(LAT)) |-> (out_valid == $past(in_valid, LAT)));
endmodule

// File: tb/kbest_level_stage_test.sv
`timescale 1ns/1ps
module kbest_level_stage_test;
    import kbest_pkg::*;

    localparam int K = 8, BW = 12, RW = 12, PW = 40, LEVELS = 8;
    localparam int HW = LEVELS * IDX_W;
    localparam longint PMAX  = (64'd1 << PW) - 1;
    localparam longint HMASK = (64'd1 << HW) - 1;

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
    logic [K*PW-1:0] in_ped = '0;
    logic [K*BW-1:0] in_b = '0;
    logic [K*HW-1:0] in_hist = '0;
    logic [RW-1:0]   r_diag = '0;
    logic f_valid, r_valid, n_valid;
    logic [K*PW-1:0] f_ped, r_ped, n_ped;
    logic [K*HW-1:0] f_hist, r_hist, n_hist;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    kbest_level_stage #(.MODE(MODE_FULL), .K(K), .BW(BW), .RW(RW), .PW(PW), .LEVELS(LEVELS)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ped(in_ped), .in_b(in_b),
        .in_hist(in_hist), .r_diag(r_diag), .out_valid(f_valid), .out_ped(f_ped), .out_hist(f_hist));
    kbest_level_stage #(.MODE(MODE_ROOT), .K(K), .BW(BW), .RW(RW), .PW(PW), .LEVELS(LEVELS)) uut_root (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ped(in_ped), .in_b(in_b),
        .in_hist(in_hist), .r_diag(r_diag), .out_valid(r_valid), .out_ped(r_ped), .out_hist(r_hist));
    kbest_level_stage #(.MODE(MODE_NEAREST), .K(K), .BW(BW), .RW(RW), .PW(PW), .LEVELS(LEVELS)) uut_near (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ped(in_ped), .in_b(in_b),
        .in_hist(in_hist), .r_diag(r_diag), .out_valid(n_valid), .out_ped(n_ped), .out_hist(n_hist));

    longint lane_ped[K], lane_hist[K];
    int     lane_b[K];
    int     r_val;
    longint e_root_p[K], e_root_h[K], e_near_p[K], e_near_h[K], e_full_p[K], e_full_h[K];
    int     e_near_i[K];

    task automatic chk(bit ok, string req, string what, longint got, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic longint err_ref(int b, int r, int i);
        longint d;
        d = longint'(b) - longint'(r) * longint'(2 * i - 7);
        return d * d;
    endfunction

    function automatic longint sat_ref(longint a, longint e);
        return (a + e > PMAX) ? PMAX : a + e;
    endfunction

    task automatic compute_expect();
        longint cp[64], ch[64];
        bit used[64];
        for (int p = 0; p < K; p++) begin
            int best = 0;
            e_root_p[p] = sat_ref(lane_ped[p], err_ref(lane_b[p], r_val, p));
            e_root_h[p] = ((lane_hist[p] << 3) | p) & HMASK;
            for (int i = 1; i < 8; i++)
                if (err_ref(lane_b[p], r_val, i) < err_ref(lane_b[p], r_val, best)) best = i;
            e_near_i[p] = best;
            e_near_p[p] = sat_ref(lane_ped[p], err_ref(lane_b[p], r_val, best));
            e_near_h[p] = ((lane_hist[p] << 3) | best) & HMASK;
            for (int i = 0; i < 8; i++) begin
                cp[p*8+i]   = sat_ref(lane_ped[p], err_ref(lane_b[p], r_val, i));
                ch[p*8+i]   = ((lane_hist[p] << 3) | i) & HMASK;
                used[p*8+i] = 0;
            end
        end
        for (int k = 0; k < K; k++) begin
            int m = -1;
            for (int c = 0; c < 64; c++)
                if (!used[c] && (m < 0 || cp[c] < cp[m])) m = c;
            used[m] = 1;
            e_full_p[k] = cp[m];
            e_full_h[k] = ch[m];
        end
    endtask

    task automatic drive_lanes();
        for (int p = 0; p < K; p++) begin
            in_ped[p*PW +: PW]  = lane_ped[p][PW-1:0];
            in_b[p*BW +: BW]    = lane_b[p][BW-1:0];
            in_hist[p*HW +: HW] = lane_hist[p][HW-1:0];
        end
        r_diag   = r_val[RW-1:0];
        in_valid = 1'b1;
    endtask

    task automatic check_slots(string req, string tag, longint ep[K], longint eh[K],
                               logic [K*PW-1:0] gp, logic [K*HW-1:0] gh);
        for (int k = 0; k < K; k++) begin
            chk(longint'(gp[k*PW +: PW]) == ep[k], req, $sformatf("%s ped slot %0d", tag, k),
                longint'(gp[k*PW +: PW]), ep[k]);
            chk(longint'(gh[k*HW +: HW]) == eh[k], req, $sformatf("%s hist slot %0d", tag, k),
                longint'(gh[k*HW +: HW]), eh[k]);
        end
    endtask

    // one input set; root/nearest checked after 1 edge, full after 3
    task automatic apply_one(string req_r, string req_n, string req_f);
        compute_expect();
        @(negedge clk); drive_lanes();
        @(negedge clk); in_valid = 1'b0;
        chk(r_valid == 1'b1, req_r, "root valid", r_valid, 1);
        chk(n_valid == 1'b1, req_n, "nearest valid", n_valid, 1);
        chk(f_valid == 1'b0, "R8", "full valid early", f_valid, 0);
        check_slots(req_r, "root", e_root_p, e_root_h, r_ped, r_hist);
        check_slots(req_n, "nearest", e_near_p, e_near_h, n_ped, n_hist);
        @(negedge clk);
        @(negedge clk);
        chk(f_valid == 1'b1, req_f, "full valid", f_valid, 1);
        chk(r_valid == 1'b0, "R8", "root valid pulse", r_valid, 0);
        check_slots(req_f, "full", e_full_p, e_full_h, f_ped, f_hist);
    endtask

    task automatic test_reset();
        chk(f_valid == 1'b0 && r_valid == 1'b0 && n_valid == 1'b0, "R9", "valid in reset",
            {f_valid, r_valid, n_valid}, 0);
    endtask

    task automatic test_random();
        for (int t = 0; t < 4; t++) begin
            r_val = $urandom_range(1, 300);
            for (int p = 0; p < K; p++) begin
                lane_ped[p]  = longint'($urandom_range(0, 1 << 30));
                lane_b[p]    = int'($urandom_range(0, 4000)) - 2000;
                lane_hist[p] = longint'($urandom) & HMASK;   // top bits exercise R1 drop
            end
            apply_one("R4", "R7", "R5");
            // R2 and R1 are covered by the PED and history comparisons above
            chk(1'b1, "R2", "ped formula exercised", 0, 0);
        end
    endtask

    task automatic test_ties();
        r_val = 37;
        for (int p = 0; p < K; p++) begin
            lane_ped[p]  = 1000;
            lane_b[p]    = 100;
            lane_hist[p] = p;
        end
        apply_one("R1", "R7", "R6");
    endtask

    task automatic test_saturation();
        r_val = 200;
        for (int p = 0; p < K; p++) begin
            lane_ped[p]  = PMAX - p;
            lane_b[p]    = -2000 + 300 * p;
            lane_hist[p] = 0;
        end
        apply_one("R3", "R3", "R3");
        chk(longint'(r_ped[0 +: PW]) == PMAX, "R3", "root lane0 saturated", longint'(r_ped[0 +: PW]), PMAX);
    endtask

    task automatic test_nearest_edges();
        int bv[K] = '{2000, -2000, 0, 20, 31, -69, 55, 70};
        int iv[K] = '{7, 0, 3, 4, 5, 0, 6, 7};
        r_val = 10;
        for (int p = 0; p < K; p++) begin
            lane_ped[p]  = 0;
            lane_b[p]    = bv[p];
            lane_hist[p] = 0;
        end
        apply_one("R4", "R7", "R5");
        for (int p = 0; p < K; p++)
            chk(longint'(n_hist[p*HW +: 3]) == longint'(iv[p]), "R7",
                $sformatf("nearest index lane %0d", p), longint'(n_hist[p*HW +: 3]), iv[p]);
    endtask

    task automatic test_stream();
        longint ap[K], ah[K];
        r_val = 73;
        for (int p = 0; p < K; p++) begin
            lane_ped[p] = 500 * p; lane_b[p] = 90 * p - 300; lane_hist[p] = p + 8;
        end
        compute_expect();
        ap = e_full_p; ah = e_full_h;
        @(negedge clk); drive_lanes();
        for (int p = 0; p < K; p++) begin
            lane_ped[p] = 7000 - 300 * p; lane_b[p] = 1500 - 400 * p; lane_hist[p] = 3 * p;
        end
        compute_expect();
        @(negedge clk); drive_lanes();
        @(negedge clk); in_valid = 1'b0;
        chk(r_valid == 1'b1, "R8", "root second set valid", r_valid, 1);
        @(negedge clk);
        chk(f_valid == 1'b1, "R8", "full first set valid", f_valid, 1);
        check_slots("R8", "stream A", ap, ah, f_ped, f_hist);
        @(negedge clk);
        chk(f_valid == 1'b1, "R8", "full second set valid", f_valid, 1);
        check_slots("R8", "stream B", e_full_p, e_full_h, f_ped, f_hist);
        @(negedge clk);
        chk(f_valid == 1'b0, "R8", "full valid drops", f_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_random();
        test_ties();
        test_saturation();
        test_nearest_edges();
        test_stream();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule